// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 40-bit physical address. It walks translation tables that live in memory, and each table entry is a 64-bit descriptor. The walk always has two levels. The first level has four entries, one for each 1 GB quarter of the virtual space, and each of these must point to a second-level table. Each second-level table has 512 entries. An entry there is a block descriptor that maps a 2 MB region, gives its cacheability and says whether privileged instruction fetch is forbidden.

A requester raises `req` with an address and a flag that marks a privileged instruction fetch. The block answers with a one-cycle `ack` that carries the physical address, the cacheable and no-execute attributes, and a fault code. Descriptors come through a simple read port. That port holds a read request until the memory answers, however many cycles the memory takes.

The block also keeps the last good 2 MB mapping. A later request in the same region is answered without any memory read. A flush, or any write of the base register, discards that stored mapping.

Top module: `ttWalker`

## Requirements
- R1: After reset, `ack` and `rdReq` are low and no mapping is stored, so the first request always reads memory.
- R2: The first read goes to `{base[39:5], va[31:30], 3'b000}`. The second read goes to `{desc1[39:12], va[29:21], 3'b000}`, where `desc1` is the first-level descriptor.
- R3: When the second-level descriptor has bits[1:0] = 01, the walk completes after exactly two reads:
  - `respPa` = `{desc2[39:21], va[20:0]}`;
  - `respCache` = bit 3 of `desc2`;
  - `respPxn` = bit 53 of `desc2`;
  - `respFault` = 0.
- R4: A first-level descriptor whose bits[1:0] are not 11 ends the walk after one read with `respFault` = 1. This covers bit 0 = 0 (invalid) and type 01 (block).
- R5: A second-level descriptor whose bits[1:0] are not 01 gives `respFault` = 2. This covers bit 0 = 0 (invalid) and type 11 (table).
- R6: A privileged instruction fetch (`reqPrivFetch` = 1) into a block with bit 53 set gives `respFault` = 3.
- R7: If any of bits [63:40] of the base register are nonzero, every walk gives `respFault` = 1 and makes no memory read.
- R8: A request whose `va[31:21]` matches the last block that was translated makes no memory read. Its `ack` comes on the clock edge after `req` is accepted. The answer carries the stored attributes and applies R6 using the current fetch flag.
- R9: A `flush` pulse, or any write of the base register, discards the stored mapping. The next request then walks the tables again.
- R10: While `rdReq` is high and `rdValid` has not yet come, `rdReq` stays high and `rdAddr` does not change.
- R11: `ack` is high for exactly one cycle. The response outputs keep their values until the next `ack`.
- R12: Whenever `respFault` is nonzero, `respPa`, `respCache` and `respPxn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baseWe | input | 1 | Writes `baseIn` into the table base register |
| baseIn | input | 64 | New table base value |
| flush | input | 1 | Discards the stored mapping |
| req | input | 1 | Translation request, held until `ack` |
| reqVa | input | 32 | Virtual address |
| reqPrivFetch | input | 1 | Marks a privileged instruction fetch |
| ack | output | 1 | One-cycle completion strobe |
| respPa | output | 40 | Physical address |
| respCache | output | 1 | Region is cacheable |
| respPxn | output | 1 | Privileged execute-never attribute |
| respFault | output | 2 | Fault code: 0 none, 1 first-level translation, 2 second-level translation, 3 permission |
| rdReq | output | 1 | Descriptor read request |
| rdAddr | output | 40 | Byte address of the descriptor |
| rdValid | input | 1 | Read data is valid |
| rdData | input | 64 | Descriptor word |

## Verification
The timing of each answer follows from the path the request takes:
- A stored-mapping hit raises `ack` on the first edge after the request is accepted.
- A bad base raises `ack` on that same first edge.
- A table walk raises `ack` one edge after the last `rdValid`.

The memory model stalls for a delay that depends on the address, so the position of `ack` moves from request to request. The bench therefore samples the outputs at the falling edge on which `ack` is first seen high. It counts the cycles only on hits, where the one-cycle latency is itself part of a requirement. Read counts and read addresses are logged by the memory model and compared at that same point.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  typedef enum logic [1:0] {
    FAULT_NONE = 2'd0,
    FAULT_L1   = 2'd1,
    FAULT_L2   = 2'd2,
    FAULT_PERM = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch request
    logic resHit;      // answer from stored mapping
    logic resL1Fault;  // answer with first-level fault
    logic l1Load;      // take second-level table base from rdData
    logic resL2;       // answer from second-level descriptor
  } strobe_t;

  localparam int DESC_W     = 64;
  localparam int BIT_CACHE  = 3;
  localparam int BIT_PXN    = 53;
  localparam logic [1:0] TYPE_TABLE = 2'b11;
  localparam logic [1:0] TYPE_BLOCK = 2'b01;
endpackage

// File: rtl/ttwCtrl.sv
module ttwCtrl
  import ttw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    rdValid,
  input  logic    hitNow,
  input  logic    baseBad,
  input  logic    l1Table,
  output strobe_t stb,
  output logic    rdReq,
  output logic    l2Phase,
  output logic    ack
);
  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_DONE} state_e;
  state_e state, nextState;

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      S_IDLE: if (req) begin
        stb.capture = 1'b1;
        if (hitNow) begin
          stb.resHit = 1'b1;
          nextState  = S_DONE;
        end else if (baseBad) begin
          stb.resL1Fault = 1'b1;
          nextState      = S_DONE;
        end else begin
          nextState = S_RD1;
        end
      end
      S_RD1: if (rdValid) begin
        if (l1Table) begin
          stb.l1Load = 1'b1;
          nextState  = S_RD2;
        end else begin
          stb.resL1Fault = 1'b1;
          nextState      = S_DONE;
        end
      end
      S_RD2: if (rdValid) begin
        stb.resL2 = 1'b1;
        nextState = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign rdReq   = (state == S_RD1) || (state == S_RD2);
  assign l2Phase = (state == S_RD2);
  assign ack     = (state == S_DONE);
endmodule

// File: rtl/ttwDatapath.sv
module ttwDatapath
  import ttw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int L1_BITS    = 2,
  parameter int L2_BITS    = 9,
  parameter int BLOCK_BITS = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              l2Phase,
  input  logic              baseWe,
  input  logic [DESC_W-1:0] baseIn,
  input  logic              flush,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqPrivFetch,
  input  logic [DESC_W-1:0] rdData,
  output logic              hitNow,
  output logic              baseBad,
  output logic              l1Table,
  output logic [PA_W-1:0]   rdAddr,
  output logic [PA_W-1:0]   respPa,
  output logic              respCache,
  output logic              respPxn,
  output logic [1:0]        respFault
);
  localparam int ENTRY_SH = 3;
  localparam int L1_ALIGN = L1_BITS + ENTRY_SH;
  localparam int L2_ALIGN = L2_BITS + ENTRY_SH;
  localparam int TAG_W    = VA_W - BLOCK_BITS;
  localparam int PAHI_W   = PA_W - BLOCK_BITS;

  logic [DESC_W-1:0]      baseReg;
  logic [VA_W-1:0]        vaReg;
  logic                   fetchReg;
  logic [PA_W-L2_ALIGN-1:0] l2Base;

  logic              hitValid;
  logic [TAG_W-1:0]  hitTag;
  logic [PAHI_W-1:0] hitPaHi;
  logic              hitCache;
  logic              hitPxn;

  logic l2Block;
  logic clearHit;

  assign baseBad  = |baseReg[DESC_W-1:PA_W];
  assign l1Table  = (rdData[1:0] == TYPE_TABLE);
  assign l2Block  = (rdData[1:0] == TYPE_BLOCK);
  assign hitNow   = hitValid && (reqVa[VA_W-1:BLOCK_BITS] == hitTag);
  assign clearHit = flush || baseWe;

  always_comb begin
    if (l2Phase)
      rdAddr = {l2Base, vaReg[BLOCK_BITS +: L2_BITS], {ENTRY_SH{1'b0}}};
    else
      rdAddr = {baseReg[PA_W-1:L1_ALIGN], vaReg[VA_W-1 -: L1_BITS], {ENTRY_SH{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      vaReg    <= '0;
      fetchReg <= 1'b0;
      l2Base   <= '0;
    end else begin
      if (baseWe)      baseReg <= baseIn;
      if (stb.capture) begin
        vaReg    <= reqVa;
        fetchReg <= reqPrivFetch;
      end
      if (stb.l1Load)  l2Base <= rdData[PA_W-1:L2_ALIGN];
    end
  end

  // stored mapping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitTag   <= '0;
      hitPaHi  <= '0;
      hitCache <= 1'b0;
      hitPxn   <= 1'b0;
    end else if (clearHit) begin
      hitValid <= 1'b0;
    end else if (stb.resL2 && l2Block) begin
      hitValid <= 1'b1;
      hitTag   <= vaReg[VA_W-1:BLOCK_BITS];
      hitPaHi  <= rdData[PA_W-1:BLOCK_BITS];
      hitCache <= rdData[BIT_CACHE];
      hitPxn   <= rdData[BIT_PXN];
    end
  end

  // response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respPa    <= '0;
      respCache <= 1'b0;
      respPxn   <= 1'b0;
      respFault <= FAULT_NONE;
    end else if (stb.resHit) begin
      if (hitPxn && reqPrivFetch) begin
        respPa    <= '0;
        respCache <= 1'b0;
        respPxn   <= 1'b0;
        respFault <= FAULT_PERM;
      end else begin
        respPa    <= {hitPaHi, reqVa[BLOCK_BITS-1:0]};
        respCache <= hitCache;
        respPxn   <= hitPxn;
        respFault <= FAULT_NONE;
      end
    end else if (stb.resL1Fault) begin
      respPa    <= '0;
      respCache <= 1'b0;
      respPxn   <= 1'b0;
      respFault <= FAULT_L1;
    end else if (stb.resL2) begin
      if (!l2Block) begin
        respPa    <= '0;
        respCache <= 1'b0;
        respPxn   <= 1'b0;
        respFault <= FAULT_L2;
      end else if (rdData[BIT_PXN] && fetchReg) begin
        respPa    <= '0;
        respCache <= 1'b0;
        respPxn   <= 1'b0;
        respFault <= FAULT_PERM;
      end else begin
        respPa    <= {rdData[PA_W-1:BLOCK_BITS], vaReg[BLOCK_BITS-1:0]};
        respCache <= rdData[BIT_CACHE];
        respPxn   <= rdData[BIT_PXN];
        respFault <= FAULT_NONE;
      end
    end
  end
endmodule

// File: rtl/ttWalker.sv
module ttWalker
  import ttw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int L1_BITS    = 2,
  parameter int L2_BITS    = 9,
  parameter int BLOCK_BITS = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [63:0]       baseIn,
  input  logic              flush,
  input  logic              req,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqPrivFetch,
  output logic              ack,
  output logic [PA_W-1:0]   respPa,
  output logic              respCache,
  output logic              respPxn,
  output logic [1:0]        respFault,
  output logic              rdReq,
  output logic [PA_W-1:0]   rdAddr,
  input  logic              rdValid,
  input  logic [63:0]       rdData
);
  strobe_t stb;
  logic hitNow, baseBad, l1Table, l2Phase;

  ttwCtrl uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .rdValid(rdValid),
    .hitNow(hitNow), .baseBad(baseBad), .l1Table(l1Table),
    .stb(stb), .rdReq(rdReq), .l2Phase(l2Phase), .ack(ack)
  );

  ttwDatapath #(
    .VA_W(VA_W), .PA_W(PA_W), .L1_BITS(L1_BITS),
    .L2_BITS(L2_BITS), .BLOCK_BITS(BLOCK_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .l2Phase(l2Phase),
    .baseWe(baseWe), .baseIn(baseIn), .flush(flush),
    .reqVa(reqVa), .reqPrivFetch(reqPrivFetch), .rdData(rdData),
    .hitNow(hitNow), .baseBad(baseBad), .l1Table(l1Table),
    .rdAddr(rdAddr), .respPa(respPa), .respCache(respCache),
    .respPxn(respPxn), .respFault(respFault)
  );
endmodule

// File: rtl/ttwChecker.sv
module ttwChecker #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rstN,
  input logic            ack,
  input logic            rdReq,
  input logic            rdValid,
  input logic [PA_W-1:0] rdAddr,
  input logic [PA_W-1:0] respPa,
  input logic            respCache,
  input logic            respPxn,
  input logic [1:0]      respFault
);
  assert_read_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  assert_resp_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ack |=> (ack || ($stable(respPa) && $stable(respFault) && $stable(respCache))));

  assert_no_read_on_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !rdReq);

  assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ack && respFault != 2'd0) |-> (respPa == '0 && !respCache && !respPxn));
endmodule

bind ttWalker ttwChecker #(.PA_W(PA_W)) uChk (
  .clk(clk), .rstN(rstN), .ack(ack), .rdReq(rdReq), .rdValid(rdValid),
  .rdAddr(rdAddr), .respPa(respPa), .respCache(respCache),
  .respPxn(respPxn), .respFault(respFault)
);

// File: tb/ttWalker_test.sv
`timescale 1ns/1ps
module ttWalker_test;
  localparam logic [39:0] L1B = 40'h00_7FFF_4000;
  localparam logic [39:0] L2B = 40'h10_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [63:0] baseIn = '0;
  logic        flush = 1'b0;
  logic        req = 1'b0;
  logic [31:0] reqVa = '0;
  logic        reqPrivFetch = 1'b0;
  logic        ack;
  logic [39:0] respPa;
  logic        respCache, respPxn;
  logic [1:0]  respFault;
  logic        rdReq;
  logic [39:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [63:0] rdData = '0;

  ttWalker uut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cycle = 0;
  int readCount = 0, waitCnt = 0, stallBad = 0, lastReads = 0;
  logic [39:0] heldAddr = '0;
  logic [39:0] addrLog [4];
  logic [1:0]  l1Mode [4];
  bit          hv = 0;
  logic [10:0] htag = '0;
  bit          baseBadNow = 0;

  function automatic logic [63:0] l2Desc(input int r, input int j);
    logic [63:0] d;
    logic [18:0] paHi;
    logic cache, pxn;
    logic [1:0] ty;
    paHi  = 19'((r * 512 + j) * 37 + 5);
    cache = (r == 1);
    pxn   = (r != 1) ^ (j % 5 == 0);
    if (j % 61 == 13)     ty = 2'b00;
    else if (j % 53 == 7) ty = 2'b11;
    else                  ty = 2'b01;
    d = '0;
    d[53] = pxn;
    d[39:21] = paHi;
    d[3] = cache;
    d[11:4] = 8'h44;
    d[1:0] = ty;
    return d;
  endfunction

  function automatic logic [63:0] memWord(input logic [39:0] a);
    logic [63:0] d;
    int r, j;
    d = '0;
    if (a >= L1B && a < L1B + 40'd32 && a[2:0] == 3'd0) begin
      r = int'((a - L1B) >> 3);
      if (l1Mode[r] == 2'd0)      d = {24'd0, L2B + 40'(r * 4096)} | 64'd3;
      else if (l1Mode[r] == 2'd2) d = {24'd0, L2B + 40'(r * 4096)} | 64'd1;
    end else if (a >= L2B && a < L2B + 40'd16384 && a[2:0] == 3'd0) begin
      r = int'((a - L2B) >> 12);
      j = int'(((a - L2B) >> 3) & 40'd511);
      d = l2Desc(r, j);
    end
    return d;
  endfunction

  // memory model with address-dependent stall
  always @(posedge clk) begin
    if (rdValid) rdValid <= 1'b0;
    else if (rdReq) begin
      if (waitCnt == 0) heldAddr <= rdAddr;
      else if (rdAddr != heldAddr) stallBad <= stallBad + 1;
      if (waitCnt >= int'((rdAddr[5:3] + rdAddr[14:12]) % 5)) begin
        rdValid <= 1'b1;
        rdData  <= memWord(rdAddr);
        addrLog[readCount % 4] <= rdAddr;
        readCount <= readCount + 1;
        waitCnt <= 0;
      end else waitCnt <= waitCnt + 1;
    end
  end

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (cycle > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic setBase(input logic [63:0] v);
    @(negedge clk); baseWe = 1'b1; baseIn = v;
    @(negedge clk); baseWe = 1'b0;
    hv = 0;
    baseBadNow = (v[63:40] != 0);
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    hv = 0;
  endtask

  task automatic doReq(input logic [31:0] va, input logic f);
    int start, cyc, r, j, expReads, expFault;
    logic [63:0] d;
    logic [39:0] expPa;
    logic expC, expP;
    bit expHit;
    string rq;
    r = int'(va[31:30]); j = int'(va[29:21]);
    d = l2Desc(r, j);
    expHit = hv && (htag == va[31:21]);
    expPa = '0; expC = 0; expP = 0;
    if (baseBadNow) begin expReads = 0; expFault = 1; rq = "R7"; end
    else if (!expHit && l1Mode[r] != 2'd0) begin expReads = 1; expFault = 1; rq = "R4"; end
    else begin
      expReads = expHit ? 0 : 2;
      if (d[1:0] != 2'b01) begin expFault = 2; rq = "R5"; end
      else if (f && d[53]) begin expFault = 3; rq = "R6"; end
      else begin
        expFault = 0; rq = expHit ? "R8" : "R3";
        expPa = {d[39:21], va[20:0]}; expC = d[3]; expP = d[53];
      end
      if (expHit && expFault == 3) rq = "R8";
    end
    @(negedge clk);
    start = readCount;
    req = 1'b1; reqVa = va; reqPrivFetch = f;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!ack && cyc < 400);
    req = 1'b0;
    lastReads = readCount - start;
    chk(ack == 1'b1, rq, "ack seen", 64'(ack), 64'd1);
    chk(respFault == 2'(expFault), rq, "fault", 64'(respFault), 64'(expFault));
    chk(respPa == expPa && respCache == expC && respPxn == expP, rq == "R3" || rq == "R8" ? rq : "R12",
        "pa/cache/pxn", {respPa, 22'd0, respCache, respPxn}, {expPa, 22'd0, expC, expP});
    chk(lastReads == expReads, rq, "read count", 64'(lastReads), 64'(expReads));
    if (expHit) chk(cyc == 1, "R8", "hit latency", 64'(cyc), 64'd1);
    if (expReads >= 1)
      chk(addrLog[start % 4] == L1B + 40'(r * 8), "R2", "L1 address",
          64'(addrLog[start % 4]), 64'(L1B + 40'(r * 8)));
    if (expReads == 2)
      chk(addrLog[(start + 1) % 4] == L2B + 40'(r * 4096 + j * 8), "R2", "L2 address",
          64'(addrLog[(start + 1) % 4]), 64'(L2B + 40'(r * 4096 + j * 8)));
    @(negedge clk);
    chk(ack == 1'b0 && respPa == expPa && respFault == 2'(expFault), "R11", "pulse/hold",
        {respPa, 21'd0, ack, respFault}, {expPa, 21'd0, 1'b0, 2'(expFault)});
    if (!baseBadNow && !expHit && l1Mode[r] == 2'd0 && d[1:0] == 2'b01) begin
      hv = 1; htag = va[31:21];
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) l1Mode[i] = 2'd0;
    repeat (3) @(negedge clk);
    chk(ack == 1'b0 && rdReq == 1'b0, "R1", "reset outputs", {62'd0, ack, rdReq}, 64'd0);
    rstN = 1'b1;
    setBase({24'd0, L1B});
    // R1: first request after reset must walk (2 reads)
    doReq(32'h4020_1234, 1'b0);
    chk(lastReads == 2, "R1", "first request walks", 64'(lastReads), 64'd2);

    // sweep all regions
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < 512; j += 3) begin
        logic [31:0] va;
        va = {2'(r), 9'(j), 21'((j * 7919) & 21'h1FFFFF)};
        doFlush();
        doReq(va, 1'(j & 1));
        doReq({va[31:21], ~va[20:0]}, 1'(~j & 1));
      end
    end

    // R9: flush and base write discard stored mapping
    doFlush();
    doReq(32'h4020_0000, 1'b0);
    doReq(32'h4020_0100, 1'b0);
    chk(lastReads == 0, "R9", "hit before flush", 64'(lastReads), 64'd0);
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    hv = 0;
    doReq(32'h4020_0200, 1'b0);
    chk(lastReads == 2, "R9", "walk after flush", 64'(lastReads), 64'd2);
    setBase({24'd0, L1B});
    doReq(32'h4020_0300, 1'b0);
    chk(lastReads == 2, "R9", "walk after base write", 64'(lastReads), 64'd2);

    // R4: invalid and block-type first-level descriptors
    l1Mode[3] = 2'd1;
    doReq(32'hC040_0000, 1'b0);
    l1Mode[3] = 2'd2;
    doReq(32'hC060_0010, 1'b0);
    l1Mode[3] = 2'd0;

    // R7: bad base upper bits
    setBase({24'h000100, L1B});
    doReq(32'h4020_0000, 1'b0);
    doReq(32'h0000_0000, 1'b1);
    setBase({24'd0, L1B});
    doReq(32'h4020_0000, 1'b0);

    chk(stallBad == 0, "R10", "address held during stall", 64'(stallBad), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule